// File: doc/BRIEF.md
# Arithmetic unit with status flag register

This block pairs an 8-bit arithmetic/logic unit with a five-flag status register that is itself addressable as a destination. Each cycle in which `wr_en` is high, the unit performs the operation picked by `op_sel` on `opnd_a` (the source register value) and `opnd_b` (the working operand). It presents the result combinationally on `result`. At the clock edge it stores that result in the addressed destination and updates the flags that the operation is defined to affect.

The flags are negative, overflow, zero, digit carry and carry. Add and subtract update all five. The logic operations update zero and negative. Clear updates zero only. Rotate through carry updates carry, zero and negative. Moves, nibble swap and single-bit set/clear leave every flag alone.

When a flag-affecting operation names the status register as its destination, the flag update wins and the computed value is discarded. A flag-neutral operation aimed at the status register writes it like any other register. A single data register at `DATA_ADDR` stands in for the register file. Any other address keeps no result, but the flags are still updated.

Top module: `alu_flag_unit`

## Requirements
- R1: `status` reads as {3'b000, N, OV, Z, DC, C}, with N at bit 4 and C at bit 0. Bits 7 to 5 always read 0. After reset the five flags and the data register are all 0.
- R2: Add (op_sel 0) gives result = a + b mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R3: Subtract (op_sel 1) computes a + ~b + 1, giving result = a - b mod 256. C and DC are the carries of that sum, so 1 means no borrow.
- R4: For add and subtract, N is result bit 7. OV is 1 when both addends (b inverted for subtract) have the same sign bit and the result's sign bit differs from it.
- R5: AND (op_sel 2), OR (op_sel 3) and XOR (op_sel 4) set Z when the result is 0 and clear it otherwise. They set N to result bit 7 and keep OV, DC and C. Add and subtract set Z by the same rule.
- R6: With `wr_en` high, a flag-affecting operation whose `dest_addr` equals STAT_ADDR does not write its result anywhere but does update the flags. Any operation whose `dest_addr` equals DATA_ADDR loads the result into the data register, shown on `wb_data`.
- R7: Clear (op_sel 5) gives result 0 and sets Z. It keeps N, OV, DC and C, including when the status register is the destination.
- R8: Move a (op_sel 6), move b (op_sel 7), nibble swap of a (op_sel 8), bit set (op_sel 9) and bit clear (op_sel 10) change no flag. For the bit operations, b[2:0] selects the bit of a. When one of these targets the status register, result bits 4 to 0 replace the flags and result bits 7 to 5 are dropped.
- R9: Rotate left (op_sel 11) gives {a[6:0], C} and loads C from a[7]. Rotate right (op_sel 12) gives {C, a[7:1]} and loads C from a[0]. Both also set Z and N from the result and keep OV and DC.
- R10: While `wr_en` is low, or for op_sel 13 to 15, neither the flags nor the data register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Execute the operation and commit at the next edge |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 8 | Source register operand |
| opnd_b | input | 8 | Working operand; bit index for set/clear |
| dest_addr | input | ADDR_W | Destination register address |
| result | output | 8 | Combinational operation result |
| wb_data | output | 8 | Data register contents |
| status | output | 8 | Status register contents |

## Verification
The bench uses signed overflow in both directions: 0x7F+1, and 0x80-1, where subtraction must invert b before the sign comparison. A design that judged overflow on the raw b would get OV wrong in the second case. It also subtracts with and without a borrow, which catches C or DC reported with the wrong polarity. It aims flag-affecting operations at the status register: an add whose result would differ from its flags, and a clear that must set Z while leaving the other flags as they were. A design that let the write win, or that cleared the whole register, shows a wrong status value. Rotates start with carry set, so a design that fed the old carry into the wrong end of the result, or took the shifted-out bit from the wrong end, gives a wrong result or carry.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        op_sel,
  input  logic [7:0]        opnd_a,
  input  logic [7:0]        opnd_b,
  input  logic [ADDR_W-1:0] dest_addr,
  output logic [7:0]        result,
  output logic [7:0]        wb_data,
  output logic [7:0]        status
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_CLR = 4'd5, OP_MVA = 4'd6, OP_MVB = 4'd7,
                         OP_SWP = 4'd8, OP_BST = 4'd9, OP_BCL = 4'd10, OP_RLC = 4'd11,
                         OP_RRC = 4'd12;

  // flag vector order: {N, OV, Z, DC, C}
  logic [4:0] flags_q, aff, flags_nx;
  logic [7:0] data_q, res, b_eff, bit_m;
  logic [8:0] sum;
  logic [4:0] low;
  logic       is_sub, valid, c_new, ov;

  assign is_sub = (op_sel == OP_SUB);
  assign b_eff  = is_sub ? ~opnd_b : opnd_b;
  assign sum    = {1'b0, opnd_a} + {1'b0, b_eff} + {8'd0, is_sub};
  assign low    = {1'b0, opnd_a[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, is_sub};
  assign ov     = (opnd_a[7] == b_eff[7]) && (sum[7] != opnd_a[7]);
  assign bit_m  = 8'b1 << opnd_b[2:0];

  always_comb begin
    res   = 8'h00;
    aff   = 5'b00000;
    valid = 1'b1;
    c_new = sum[8];
    case (op_sel)
      OP_ADD, OP_SUB: begin res = sum[7:0];        aff = 5'b11111; end
      OP_AND:         begin res = opnd_a & opnd_b; aff = 5'b10100; end
      OP_OR:          begin res = opnd_a | opnd_b; aff = 5'b10100; end
      OP_XOR:         begin res = opnd_a ^ opnd_b; aff = 5'b10100; end
      OP_CLR:         begin res = 8'h00;           aff = 5'b00100; end
      OP_MVA:         res = opnd_a;
      OP_MVB:         res = opnd_b;
      OP_SWP:         res = {opnd_a[3:0], opnd_a[7:4]};
      OP_BST:         res = opnd_a | bit_m;
      OP_BCL:         res = opnd_a & ~bit_m;
      OP_RLC: begin res = {opnd_a[6:0], flags_q[0]}; aff = 5'b10101; c_new = opnd_a[7]; end
      OP_RRC: begin res = {flags_q[0], opnd_a[7:1]}; aff = 5'b10101; c_new = opnd_a[0]; end
      default: valid = 1'b0;
    endcase
  end

  assign flags_nx = (flags_q & ~aff) | ({res[7], ov, res == 8'h00, low[4], c_new} & aff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 5'b0;
      data_q  <= 8'h00;
    end else if (wr_en && valid) begin
      if (dest_addr == STAT_ADDR && aff == 5'b0) flags_q <= res[4:0];
      else                                        flags_q <= flags_nx;
      if (dest_addr == DATA_ADDR) data_q <= res;
    end
  end

  assign result  = res;
  assign wb_data = data_q;
  assign status  = {3'b000, flags_q};

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && valid) |=> ($stable(status) && $stable(wb_data)));

  p_stat_dest_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dest_addr == STAT_ADDR) |=> $stable(wb_data));

  p_clr_sets_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel == OP_CLR) |=>
      (status[2] && status[4:3] == $past(status[4:3]) && status[1:0] == $past(status[1:0])));

  p_neutral_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && valid && aff == 5'b0 && dest_addr != STAT_ADDR) |=> $stable(status));

  p_neg_tracks_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && aff[4]) |=> (status[4] == $past(result[7])));

  p_upper_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STAT = 8'hF0, DATA = 8'h20, OTHER = 8'h44;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] opnd_a = 8'h00, opnd_b = 8'h00, dest_addr = 8'h00;
  logic [7:0] result, wb_data, status;
  int total = 0, bad = 0;
  logic [7:0] last_res;

  alu_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .dest_addr(dest_addr), .result(result), .wb_data(wb_data),
    .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] dst, input logic en);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; dest_addr = dst; wr_en = en;
    #1 last_res = result;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset status", status, 8'h00);
    check("R1 reset data", wb_data, 8'h00);
  endtask

  task automatic t_add;
    run_op(4'd0, 8'h7F, 8'h01, DATA, 1'b1);
    check("R2 add result", last_res, 8'h80);
    check("R4 add pos overflow flags", status, 8'h1A);
    check("R6 add to data", wb_data, 8'h80);
    run_op(4'd0, 8'hFF, 8'h01, OTHER, 1'b1);
    check("R2 add wrap carry flags", status, 8'h07);
    check("R6 other dest keeps data", wb_data, 8'h80);
  endtask

  task automatic t_sub;
    run_op(4'd1, 8'h05, 8'h03, DATA, 1'b1);
    check("R3 sub result", last_res, 8'h02);
    check("R3 sub no borrow flags", status, 8'h03);
    run_op(4'd1, 8'h03, 8'h05, OTHER, 1'b1);
    check("R3 sub borrow flags", status, 8'h10);
    run_op(4'd1, 8'h80, 8'h01, OTHER, 1'b1);
    check("R4 sub neg overflow result", last_res, 8'h7F);
    check("R4 sub neg overflow flags", status, 8'h09);
  endtask

  task automatic t_logic;
    run_op(4'd2, 8'hF0, 8'h0F, OTHER, 1'b1);
    check("R5 and zero flags", status, 8'h0D);
    run_op(4'd4, 8'hFF, 8'h0F, OTHER, 1'b1);
    check("R5 xor result", last_res, 8'hF0);
    check("R5 xor neg flags", status, 8'h19);
    run_op(4'd3, 8'h01, 8'h02, DATA, 1'b1);
    check("R5 or result to data", wb_data, 8'h03);
    check("R5 or flags", status, 8'h09);
  endtask

  task automatic t_rotate;
    run_op(4'd11, 8'h81, 8'h00, OTHER, 1'b1);
    check("R9 rotate left result", last_res, 8'h03);
    check("R9 rotate left flags", status, 8'h09);
    run_op(4'd12, 8'h02, 8'h00, OTHER, 1'b1);
    check("R9 rotate right result", last_res, 8'h81);
    check("R9 rotate right flags", status, 8'h18);
  endtask

  task automatic t_stat_dest;
    run_op(4'd0, 8'h0F, 8'h0F, STAT, 1'b1);
    check("R6 add to status flags win", status, 8'h02);
    check("R6 status dest keeps data", wb_data, 8'h03);
    run_op(4'd6, 8'hFB, 8'h00, STAT, 1'b1);
    check("R8 move to status upper dropped", status, 8'h1B);
    run_op(4'd5, 8'h55, 8'h00, STAT, 1'b1);
    check("R7 clear status sets z only", status, 8'h1F);
    run_op(4'd6, 8'h00, 8'h00, STAT, 1'b1);
    check("R8 move zero to status", status, 8'h00);
    run_op(4'd5, 8'h00, 8'h00, STAT, 1'b1);
    check("R7 clear status from zero", status, 8'h04);
    run_op(4'd5, 8'h00, 8'h00, DATA, 1'b1);
    check("R7 clear data", wb_data, 8'h00);
    check("R7 clear data flags", status, 8'h04);
  endtask

  task automatic t_neutral;
    run_op(4'd8, 8'h3C, 8'h00, DATA, 1'b1);
    check("R8 swap data", wb_data, 8'hC3);
    check("R8 swap flags kept", status, 8'h04);
    run_op(4'd9, 8'h00, 8'h05, DATA, 1'b1);
    check("R8 bit set", wb_data, 8'h20);
    run_op(4'd10, 8'hFF, 8'h00, DATA, 1'b1);
    check("R8 bit clear", wb_data, 8'hFE);
    run_op(4'd7, 8'h00, 8'h5A, DATA, 1'b1);
    check("R8 move b", wb_data, 8'h5A);
    check("R8 move flags kept", status, 8'h04);
    run_op(4'd9, 8'h04, 8'h00, STAT, 1'b1);
    check("R8 bit set on status", status, 8'h05);
  endtask

  task automatic t_idle;
    run_op(4'd0, 8'hFF, 8'h01, DATA, 1'b0);
    check("R10 disabled status", status, 8'h05);
    check("R10 disabled data", wb_data, 8'h5A);
    run_op(4'd13, 8'hFF, 8'hFF, DATA, 1'b1);
    check("R10 unused op status", status, 8'h05);
    check("R10 unused op data", wb_data, 8'h5A);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD*3);
        @(negedge clk) rst_n = 1'b1;
        t_reset(); t_add(); t_sub(); t_logic(); t_rotate();
        t_stat_dest(); t_neutral(); t_idle();
      end
      begin
        #(CLK_PERIOD*5000);
        total++; bad++;
        $display("FAIL watchdog expired actual=00 expected=01");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule